// File: doc/BRIEF.md
# SPI Register Bank Slave

This block lets an external SPI host configure and read back a bank of 8-bit control registers and reach a byte-wide transmit and receive FIFO, all with fixed 16-bit frames. Each frame begins with a header byte that holds a direction flag and a 7-bit address. A data byte follows. On a write the host supplies the data byte. On a read the block returns the addressed value in that same data byte, so a read needs only one frame.

The SPI pins are brought into the system clock domain through synchronizers, and SCK is oversampled, so SCK must run well below the system clock. In the bench the SCK half period is 8 system clocks. A frame state machine steps through `FR_IDLE`, `FR_HEADER`, `FR_PAYLOAD`, `FR_COMMIT` and `FR_DRAIN`:
- Chip select going low moves it from `FR_IDLE` to `FR_HEADER`.
- The eighth rising SCK edge moves it to `FR_PAYLOAD`. At that edge the block also fetches the read byte.
- The sixteenth rising edge moves it to `FR_COMMIT`, which lasts one cycle and applies every side effect of the frame.
- It then waits in `FR_DRAIN` until chip select rises.
- Chip select going high in any state returns it to `FR_IDLE`.

Address 0 is not a storage register. A write to it pushes the data byte into the transmit FIFO, and a read from it pops the receive FIFO. Addresses 1 to 30 are plain read/write registers, and their contents are exported to the serial datapath. Address 31 is a read-only revision code.

Top module: `spi_regbank`

## Requirements
- R1: A frame is 16 bits sent MSB first. Bit 15 = 1 marks a write and 0 marks a read. Bits 14:8 are the address and bits 7:0 are the write data. A completed write to address 1..30 stores the byte, and the byte appears on `cfg_regs[8*a +: 8]`.
- R2: SPI mode 0 is used. During a read, MISO carries the addressed byte MSB first during bits 7:0 and is valid at each rising SCK edge of that byte. MISO is 0 during the header byte.
- R3: A completed write to address 0 gives exactly one `tx_push` pulse with `tx_data` equal to the data byte. No register changes.
- R4: A completed read of address 0 returns `rx_data` as it was at the end of the header byte and gives exactly one `rx_pop` pulse. If `rx_empty` was 1, the read returns 0x00 and there is no pop.
- R5: Address 31 reads as the parameter `REV_ID` (default 0xA0). Writes to address 31 are ignored.
- R6: Addresses 32..127 read as 0x00. Writes to them change no register and push nothing.
- R7: If chip select rises before the sixteenth rising SCK edge, the frame is dropped: no register write, no push and no pop.
- R8: While chip select is high, `spi_miso_oe` = 0 and `spi_miso` = 0. `spi_miso_oe` = 1 during a frame.
- R9: After reset, registers 1..30 hold 0x00.
- R10: `tx_push` and `rx_pop` are single-cycle pulses and are never active together. SCK edges after the sixteenth, within the same frame, cause no further effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Host-to-slave data |
| spi_miso | output | 1 | Slave-to-host data |
| spi_miso_oe | output | 1 | MISO drive enable |
| tx_push | output | 1 | Transmit FIFO push strobe |
| tx_data | output | 8 | Byte to push into the transmit FIFO |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| rx_data | input | 8 | Head entry of the receive FIFO |
| rx_empty | input | 1 | Receive FIFO is empty |
| cfg_regs | output | 8*NREG | All register slots, 8 bits per address |

## Verification
The bench goes after the byte boundary of a read. If the fetch happens one SCK edge late, the MSB of the returned data shifts by one bit position. If MISO drives before the header completes, junk appears in the upper byte. It also targets FIFO side effects: popping when empty, popping at the header rather than at frame end, or pushing on an aborted frame each leaves the push or pop count off by one. It also exercises the edges of the map (address 0, 31, and an out-of-range address) and overrun SCK pulses, where a design that does not decode completely or stop after sixteen bits would corrupt a register or issue a second strobe.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

    localparam int FRAME_BITS = 16;
    localparam int HDR_BITS   = 8;
    localparam int ADDR_W     = 7;
    localparam int DATA_W     = 8;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_HEADER,
        FR_PAYLOAD,
        FR_COMMIT,
        FR_DRAIN
    } frame_state_e;

endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe[i] <= RST_VAL;
            end
        end else begin
            pipe[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign sync_out = pipe[STAGES-1];

endmodule

// File: rtl/spireg_frame.sv
module spireg_frame
    import spireg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_byte,
    output logic              hdr_done,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_write,
    output logic [DATA_W-1:0] wr_byte,
    output logic              wr_commit,
    output logic              rd_commit,
    output logic              miso,
    output logic              miso_oe
);

    frame_state_e state_q, state_d;

    logic              sck_prev;
    logic              sck_rise, sck_fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [HDR_BITS-2:0] hdr_sr;
    logic [HDR_BITS-1:0] hdr_q;
    logic [DATA_W-1:0] data_sr;
    logic [DATA_W-1:0] rd_sr;
    logic              miso_q;
    logic              last_hdr_bit, last_frame_bit;

    assign sck_rise       = sck_s & ~sck_prev;
    assign sck_fall       = ~sck_s & sck_prev;
    assign last_hdr_bit   = (bit_cnt == CNT_W'(HDR_BITS - 1));
    assign last_frame_bit = (bit_cnt == CNT_W'(FRAME_BITS - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_IDLE:    if (!cs_n_s) state_d = FR_HEADER;
            FR_HEADER:  if (cs_n_s) state_d = FR_IDLE;
                        else if (sck_rise && last_hdr_bit) state_d = FR_PAYLOAD;
            FR_PAYLOAD: if (cs_n_s) state_d = FR_IDLE;
                        else if (sck_rise && last_frame_bit) state_d = FR_COMMIT;
            FR_COMMIT:  state_d = cs_n_s ? FR_IDLE : FR_DRAIN;
            FR_DRAIN:   if (cs_n_s) state_d = FR_IDLE;
            default:    state_d = FR_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        hdr_done  = 1'b0;
        wr_commit = 1'b0;
        rd_commit = 1'b0;
        miso_oe   = 1'b0;
        acc_addr  = hdr_q[ADDR_W-1:0];
        acc_write = hdr_q[HDR_BITS-1];
        unique case (state_q)
            FR_IDLE: ;
            FR_HEADER: begin
                miso_oe = 1'b1;
                if (sck_rise && last_hdr_bit) begin
                    hdr_done  = 1'b1;
                    acc_addr  = {hdr_sr[ADDR_W-2:0], mosi_s};
                    acc_write = hdr_sr[HDR_BITS-2];
                end
            end
            FR_PAYLOAD: miso_oe = 1'b1;
            FR_COMMIT: begin
                miso_oe   = 1'b1;
                wr_commit = hdr_q[HDR_BITS-1];
                rd_commit = ~hdr_q[HDR_BITS-1];
            end
            FR_DRAIN: miso_oe = 1'b1;
            default: ;
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            bit_cnt  <= '0;
            hdr_sr   <= '0;
            hdr_q    <= '0;
            data_sr  <= '0;
            rd_sr    <= '0;
            miso_q   <= 1'b0;
        end else begin
            sck_prev <= sck_s;
            unique case (state_q)
                FR_IDLE: begin
                    bit_cnt <= '0;
                    miso_q  <= 1'b0;
                end
                FR_HEADER: begin
                    miso_q <= 1'b0;
                    if (sck_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        hdr_sr  <= {hdr_sr[HDR_BITS-3:0], mosi_s};
                        if (last_hdr_bit) begin
                            hdr_q <= {hdr_sr, mosi_s};
                            rd_sr <= rd_byte;
                        end
                    end
                end
                FR_PAYLOAD: begin
                    if (sck_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                        data_sr <= {data_sr[DATA_W-2:0], mosi_s};
                    end
                    if (sck_fall) begin
                        miso_q <= rd_sr[DATA_W-1];
                        rd_sr  <= {rd_sr[DATA_W-2:0], 1'b0};
                    end
                end
                FR_COMMIT, FR_DRAIN: begin
                    if (sck_fall) miso_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assign wr_byte = data_sr;
    assign miso    = miso_q & miso_oe;

endmodule

// File: rtl/spireg_bank.sv
module spireg_bank
    import spireg_pkg::*;
#(
    parameter int          NREG   = 32,
    parameter logic [7:0]  REV_ID = 8'hA0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hdr_done,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic                   acc_write,
    input  logic [DATA_W-1:0]      wr_byte,
    input  logic                   wr_commit,
    input  logic                   rd_commit,
    input  logic [DATA_W-1:0]      rx_data,
    input  logic                   rx_empty,
    output logic [DATA_W-1:0]      rd_byte,
    output logic                   tx_push,
    output logic                   rx_pop,
    output logic [DATA_W*NREG-1:0] cfg_regs
);

    localparam int REV_ADDR = NREG - 1;

    logic [DATA_W-1:0] slot [NREG];
    logic              pop_armed;
    logic              is_fifo;

    assign is_fifo = (acc_addr == '0);

    assign slot[0]        = '0;
    assign slot[REV_ADDR] = REV_ID;

    genvar g;
    generate
        for (g = 1; g < REV_ADDR; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) slot[g] <= '0;
                else if (wr_commit && acc_addr == ADDR_W'(g)) slot[g] <= wr_byte;
            end
        end
        for (g = 0; g < NREG; g++) begin : g_flat
            assign cfg_regs[DATA_W*g +: DATA_W] = slot[g];
        end
    endgenerate

    // Read data chosen when the header completes
    always_comb begin
        if (is_fifo)                      rd_byte = rx_empty ? '0 : rx_data;
        else if (32'(acc_addr) < NREG)    rd_byte = slot[acc_addr[$clog2(NREG)-1:0]];
        else                              rd_byte = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pop_armed <= 1'b0;
        else if (hdr_done) pop_armed <= is_fifo && !acc_write && !rx_empty;
    end

    assign tx_push = wr_commit && is_fifo;
    assign rx_pop  = rd_commit && pop_armed;

endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
    import spireg_pkg::*;
#(
    parameter int         NREG        = 32,
    parameter logic [7:0] REV_ID      = 8'hA0,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  spi_sck,
    input  logic                  spi_cs_n,
    input  logic                  spi_mosi,
    output logic                  spi_miso,
    output logic                  spi_miso_oe,
    output logic                  tx_push,
    output logic [7:0]            tx_data,
    output logic                  rx_pop,
    input  logic [7:0]            rx_data,
    input  logic                  rx_empty,
    output logic [8*NREG-1:0]     cfg_regs
);

    logic [2:0]        pins_s;
    logic              hdr_done, acc_write, wr_commit, rd_commit;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] wr_byte, rd_byte;

    spireg_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({spi_sck, spi_cs_n, spi_mosi}),
        .sync_out (pins_s)
    );

    spireg_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (pins_s[2]),
        .cs_n_s    (pins_s[1]),
        .mosi_s    (pins_s[0]),
        .rd_byte   (rd_byte),
        .hdr_done  (hdr_done),
        .acc_addr  (acc_addr),
        .acc_write (acc_write),
        .wr_byte   (wr_byte),
        .wr_commit (wr_commit),
        .rd_commit (rd_commit),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe)
    );

    spireg_bank #(
        .NREG   (NREG),
        .REV_ID (REV_ID)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_done  (hdr_done),
        .acc_addr  (acc_addr),
        .acc_write (acc_write),
        .wr_byte   (wr_byte),
        .wr_commit (wr_commit),
        .rd_commit (rd_commit),
        .rx_data   (rx_data),
        .rx_empty  (rx_empty),
        .rd_byte   (rd_byte),
        .tx_push   (tx_push),
        .rx_pop    (rx_pop),
        .cfg_regs  (cfg_regs)
    );

    assign tx_data = wr_byte;

endmodule

// File: rtl/spireg_checker.sv
module spireg_checker (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_miso,
    input logic spi_miso_oe,
    input logic tx_push,
    input logic rx_pop,
    input logic rx_empty
);

    assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_push && rx_pop));

    assert_push_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |=> !tx_push);

    assert_pop_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> !rx_pop);

    assert_pop_not_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> !rx_empty);

    assert_quiet_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)
         && $past(spi_cs_n, 4)) |-> (!spi_miso_oe && !spi_miso));

endmodule

bind spi_regbank spireg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (spi_cs_n),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe),
    .tx_push     (tx_push),
    .rx_pop      (rx_pop),
    .rx_empty    (rx_empty)
);

// File: tb/spi_regbank_test.sv
`timescale 1ns/1ps
module spi_regbank_test;

    localparam int NREG = 32;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso, spi_miso_oe, tx_push, rx_pop, rx_empty;
    logic [7:0] tx_data, rx_data;
    logic [8*NREG-1:0] cfg_regs;

    int n_cmp = 0, n_bad = 0;
    int push_cnt = 0, pop_cnt = 0;
    logic [7:0] last_push = '0;
    logic [7:0] rxq [8];
    int rx_head = 0, rx_tail = 0;
    logic [7:0] exp_reg [NREG];
    bit finished = 0;

    always #2.5 clk = ~clk;

    spi_regbank uut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .tx_push(tx_push), .tx_data(tx_data), .rx_pop(rx_pop),
        .rx_data(rx_data), .rx_empty(rx_empty), .cfg_regs(cfg_regs)
    );

    assign rx_data  = rxq[rx_head[2:0]];
    assign rx_empty = (rx_head >= rx_tail);

    always @(posedge clk) begin
        if (tx_push) begin push_cnt <= push_cnt + 1; last_push <= tx_data; end
        if (rx_pop)  begin pop_cnt <= pop_cnt + 1; rx_head <= rx_head + 1; end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frame(input logic [15:0] word, input int nbits,
                         output logic [7:0] rbyte, output logic [7:0] upper);
        rbyte = '0; upper = '0;
        @(negedge clk); spi_cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 16) ? word[15-i] : 1'b0;
            repeat (HALF) @(negedge clk);
            if (i < 8)       upper = upper | {7'd0, spi_miso};
            else if (i < 16) rbyte[15-i] = spi_miso;
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (2*HALF) @(negedge clk);
    endtask

    function automatic logic [7:0] slot(input int a);
        return cfg_regs[8*a +: 8];
    endfunction

    task automatic do_write(input int a, input logic [7:0] d);
        logic [7:0] r, u;
        frame({1'b1, 7'(a), d}, 16, r, u);
    endtask

    task automatic do_read(input int a, output logic [7:0] r);
        logic [7:0] u;
        frame({1'b0, 7'(a), 8'h00}, 16, r, u);
    endtask

    task automatic t_reset;
        logic [7:0] r;
        for (int a = 1; a < NREG-1; a++) check("R9 reset slot", slot(a), 8'h00);
        check("R8 oe idle", spi_miso_oe, 1'b0);
        check("R8 miso idle", spi_miso, 1'b0);
        do_read(5, r);
        check("R9 reset readback", r, 8'h00);
    endtask

    task automatic t_regs;
        logic [7:0] r, u;
        do_write(5, 8'h3C);  exp_reg[5]  = 8'h3C;
        do_write(1, 8'h81);  exp_reg[1]  = 8'h81;
        do_write(30, 8'hFF); exp_reg[30] = 8'hFF;
        check("R1 slot5", slot(5), 8'h3C);
        check("R1 slot1", slot(1), 8'h81);
        check("R1 slot30", slot(30), 8'hFF);
        frame({1'b0, 7'd5, 8'h00}, 16, r, u);
        check("R2 read 5", r, 8'h3C);
        check("R2 header quiet", u, 8'h00);
        do_read(1, r);  check("R2 read 1", r, 8'h81);
        do_read(30, r); check("R2 read 30", r, 8'hFF);
    endtask

    task automatic t_tx;
        int pc = push_cnt;
        do_write(0, 8'h5A);
        check("R3 push count", push_cnt, pc + 1);
        check("R3 push data", last_push, 8'h5A);
        check("R3 slot0 untouched", slot(0), 8'h00);
        check("R3 slot5 untouched", slot(5), exp_reg[5]);
    endtask

    task automatic t_rx;
        logic [7:0] r;
        int qc = pop_cnt;
        rxq[0] = 8'hC3; rxq[1] = 8'h17; rx_head = 0; rx_tail = 2;
        do_read(0, r); check("R4 first entry", r, 8'hC3);
        check("R4 one pop", pop_cnt, qc + 1);
        do_read(0, r); check("R4 second entry", r, 8'h17);
        do_read(0, r); check("R4 empty returns zero", r, 8'h00);
        check("R4 no pop when empty", pop_cnt, qc + 2);
    endtask

    task automatic t_rev;
        logic [7:0] r;
        do_read(31, r); check("R5 revision", r, 8'hA0);
        do_write(31, 8'h55);
        do_read(31, r); check("R5 write ignored", r, 8'hA0);
    endtask

    task automatic t_unmapped;
        logic [7:0] r;
        int pc = push_cnt;
        do_write(64, 8'h77);
        for (int a = 1; a < NREG-1; a++) check("R6 no slot change", slot(a), exp_reg[a]);
        check("R6 no push", push_cnt, pc);
        do_read(64, r);  check("R6 read zero", r, 8'h00);
        do_read(127, r); check("R6 read top zero", r, 8'h00);
    endtask

    task automatic t_abort;
        logic [7:0] r, u;
        int pc = push_cnt, qc;
        frame({1'b1, 7'd5, 8'h11}, 12, r, u);
        check("R7 aborted write", slot(5), exp_reg[5]);
        frame({1'b1, 7'd0, 8'h22}, 15, r, u);
        check("R7 aborted push", push_cnt, pc);
        rxq[2] = 8'h9E; rx_head = 2; rx_tail = 3; qc = pop_cnt;
        frame({1'b0, 7'd0, 8'h00}, 10, r, u);
        check("R7 aborted pop", pop_cnt, qc);
        do_read(0, r); check("R7 entry kept", r, 8'h9E);
    endtask

    task automatic t_oe;
        @(negedge clk); spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        check("R8 oe in frame", spi_miso_oe, 1'b1);
        spi_cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
        check("R8 oe released", spi_miso_oe, 1'b0);
        check("R8 miso low", spi_miso, 1'b0);
    endtask

    task automatic t_overrun;
        logic [7:0] r, u;
        int pc = push_cnt;
        frame({1'b1, 7'd0, 8'hA5}, 20, r, u);
        check("R10 single push", push_cnt, pc + 1);
        check("R10 push data", last_push, 8'hA5);
        frame({1'b1, 7'd7, 8'h6E}, 19, r, u); exp_reg[7] = 8'h6E;
        check("R10 extra edges ignored", slot(7), 8'h6E);
    endtask

    initial begin
        for (int a = 0; a < NREG; a++) exp_reg[a] = '0;
        for (int i = 0; i < 8; i++) rxq[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_regs();
        t_tx();
        t_rx();
        t_rev();
        t_unmapped();
        t_abort();
        t_oe();
        t_overrun();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule